// File: doc/BRIEF.md
# Triggered Trace Capture Buffer

This block records snapshots of a group of single-bit signals and up to six 16-bit words into an on-chip trace RAM. It works like a small logic analyser. A start command loads the configuration and arms capture. From then on, one snapshot is written on every sample strobe. The strobe comes from one of three sources: a periodic timer counting 10 ms ticks, a once-per-scan pulse, or an explicit sample-request pulse.

The buffer is written circularly until the trigger input is seen high on a sample. That sample is the trigger point. A signed delay, counted in samples, positions the kept window around it:
- A negative delay keeps history from before the trigger.
- A positive delay skips samples after the trigger.

Capture ends by itself once the window is full. The stored samples can then be read back by index, counting from the oldest.

The usable depth shrinks as more word lanes are enabled, because the same storage budget must hold wider samples. The permitted delay range scales with that depth. An out-of-range delay is clamped and an error flag is set.

Top module: `trace_capture`

## Requirements
- R1: While rst_ni is low, busy_o, triggered_o, done_o and err_o are all 0.
- R2: A start_i pulse latches mode, period, word count and delay. In the next cycle busy_o is 1 and triggered_o and done_o are 0. A start while a capture is running restarts it from an empty buffer.
- R3: Mode encoding of mode_i: 0 takes a sample on every period_i-th tick_i pulse; 1 takes a sample on each scan_i pulse; 2 takes a sample on each req_i pulse. Strobes of the sources not selected are ignored.
- R4: The first sample, taken while armed, on which trig_i is 1 is the trigger point, including the very first sample after start. triggered_o rises with it.
- R5: The depth for k enabled words (nwords_i, values above 6 act as 6) is 2*floor(MEM_UNITS/(4+2k)). With MEM_UNITS=800 this gives 400, 266, 200, 160, 132, 114 and 100 for k = 0 to 6.
- R6: With trigger sample T, delay d and depth D, the kept window is samples T+d to T+d+D-1. On the strobe that stores sample T+d+D-1, done_o goes to 1 and busy_o goes to 0.
- R7: The delay is limited to the range 1-D/2 to D/2. A delay outside that range is clamped to the nearer limit, and err_o is 1 until the next start. An in-range delay leaves err_o at 0.
- R8: With rd_idx_i = i, the registered outputs one cycle later give sample i of the window (0 is the oldest). Bit channels appear on rd_bits_o. Word lane j appears on rd_words_o[16j+15:16j]. Lanes j at or above the word count read as 0.
- R9: After done_o is set, further strobes leave the stored window and done_o unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load configuration and arm capture |
| mode_i | input | 2 | Sample strobe source select |
| period_i | input | 8 | Timer period in ticks |
| nwords_i | input | 3 | Number of enabled word lanes |
| delay_i | input | DLY_W | Signed trigger delay in samples |
| tick_i | input | 1 | 10 ms timebase pulse |
| scan_i | input | 1 | Scan-cycle pulse |
| req_i | input | 1 | Explicit sample request pulse |
| trig_i | input | 1 | Trigger condition |
| bits_i | input | NBITS | Bit channels |
| words_i | input | NWORDS_MAX*WORD_W | Word channels, lane j at [16j+15:16j] |
| rd_idx_i | input | AW | Readback index from oldest sample |
| rd_bits_o | output | NBITS | Read bit channels |
| rd_words_o | output | NWORDS_MAX*WORD_W | Read word lanes |
| busy_o | output | 1 | Capture armed and running |
| triggered_o | output | 1 | Trigger point seen |
| done_o | output | 1 | Window complete |
| err_o | output | 1 | Delay was clamped |

## Verification
The assertions are checked on every cycle and cover the status handshake:
- start always re-arms with triggered and done cleared;
- done rises only after a trigger and never together with busy;
- a set done is held, and err only changes on start.

Only the bench scenarios can show the data-path behaviour:
- which samples land in the window for positive, negative and clamped delays;
- how deep the buffer is for each word count;
- that unselected strobe sources and late strobes leave the readback untouched.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_SCAN  = 2'd1,
    MODE_REQ   = 2'd2,
    MODE_OFF   = 2'd3
  } trc_mode_e;

  // samples per word count: storage units split into (2+k)-unit samples, kept even
  function automatic int depth_of(input int units, input int k);
    return 2 * (units / (4 + 2 * k));
  endfunction
endpackage

// File: rtl/trc_strobe.sv
module trc_strobe (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] per_i,
  input  logic       tick_i,
  input  logic       scan_i,
  input  logic       req_i,
  output logic       stb_o
);
  import trc_pkg::*;

  logic [7:0] cnt_q;
  logic [7:0] per_last;
  logic       cnt_hit;

  assign per_last = (per_i == 8'd0) ? 8'd0 : per_i - 8'd1;
  assign cnt_hit  = (cnt_q == per_last);

  always_comb begin
    unique case (trc_mode_e'(mode_i))
      MODE_TIMER: stb_o = en_i & tick_i & cnt_hit;
      MODE_SCAN:  stb_o = en_i & scan_i;
      MODE_REQ:   stb_o = en_i & req_i;
      default:    stb_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && tick_i && trc_mode_e'(mode_i) == MODE_TIMER) begin
      cnt_q <= cnt_hit ? 8'd0 : cnt_q + 8'd1;
    end
  end
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int DW    = 127,
  parameter int DEPTH = 400,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
    rd_o <= mem_q[ra_i];
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl #(
  parameter int MEM_UNITS  = 800,
  parameter int NWORDS_MAX = 6,
  parameter int AW         = 9,
  parameter int CW         = 11,
  parameter int DLY_W      = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              mode_i,
  input  logic [7:0]              period_i,
  input  logic [2:0]              nwords_i,
  input  logic signed [DLY_W-1:0] delay_i,
  input  logic                    stb_i,
  input  logic                    trig_i,
  input  logic [AW-1:0]           rd_idx_i,
  output logic [1:0]              mode_o,
  output logic [7:0]              per_o,
  output logic [2:0]              nw_o,
  output logic                    we_o,
  output logic [AW-1:0]           wa_o,
  output logic [AW-1:0]           ra_o,
  output logic                    busy_o,
  output logic                    trig_o,
  output logic                    done_o,
  output logic                    err_o
);
  localparam logic [2:0] NW_MAX = 3'(NWORDS_MAX);

  logic [CW-1:0] dep_tab [NWORDS_MAX+1];
  for (genvar g = 0; g <= NWORDS_MAX; g++) begin : g_dep
    assign dep_tab[g] = CW'(trc_pkg::depth_of(MEM_UNITS, g));
  end

  logic [2:0]              nw_sel;
  logic [CW-1:0]           dep_new;
  logic signed [DLY_W-1:0] hi_s, lo_s, dly_new;
  logic                    clamp;

  always_comb begin
    nw_sel  = (nwords_i > NW_MAX) ? NW_MAX : nwords_i;
    dep_new = dep_tab[nw_sel];
    hi_s    = DLY_W'(dep_new >> 1);
    lo_s    = DLY_W'(1) - hi_s;
    clamp   = 1'b1;
    if (delay_i < lo_s)      dly_new = lo_s;
    else if (delay_i > hi_s) dly_new = hi_s;
    else begin
      dly_new = delay_i;
      clamp   = 1'b0;
    end
  end

  logic                    busy_q, trig_q, done_q, err_q;
  logic [AW-1:0]           wp_q;
  logic [CW-1:0]           nst_q, rem_q, dep_q;
  logic signed [DLY_W-1:0] dly_q;
  logic [1:0]              mode_q;
  logic [7:0]              per_q;
  logic [2:0]              nw_q;

  logic          wr;
  logic [CW-1:0] rem_init, wpx, old, sum;
  int            rem_sum;

  assign wr = busy_q & stb_i;

  always_comb begin
    // writes still due after the trigger sample: D + d - 1
    rem_sum  = int'(dep_q) + int'(dly_q) - 1;
    rem_init = CW'(rem_sum);
    wpx      = CW'(wp_q);
    old      = (wpx >= nst_q) ? wpx - nst_q : wpx + dep_q - nst_q;
    sum      = old + CW'(rd_idx_i);
    ra_o     = AW'((sum >= dep_q) ? sum - dep_q : sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      trig_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wp_q   <= '0;
      nst_q  <= '0;
      rem_q  <= '0;
      dep_q  <= '0;
      dly_q  <= '0;
      mode_q <= 2'd3;
      per_q  <= '0;
      nw_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      trig_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= clamp;
      wp_q   <= '0;
      nst_q  <= '0;
      rem_q  <= '0;
      dep_q  <= dep_new;
      dly_q  <= dly_new;
      mode_q <= mode_i;
      per_q  <= period_i;
      nw_q   <= nw_sel;
    end else if (wr) begin
      wp_q  <= (wpx == dep_q - CW'(1)) ? '0 : wp_q + AW'(1);
      nst_q <= (nst_q == dep_q) ? nst_q : nst_q + CW'(1);
      if (!trig_q) begin
        if (trig_i) begin
          trig_q <= 1'b1;
          rem_q  <= rem_init;
        end
      end else begin
        if (rem_q == CW'(1)) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end
        rem_q <= rem_q - CW'(1);
      end
    end
  end

  assign we_o   = wr;
  assign wa_o   = wp_q;
  assign mode_o = mode_q;
  assign per_o  = per_q;
  assign nw_o   = nw_q;
  assign busy_o = busy_q;
  assign trig_o = trig_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int MEM_UNITS  = 800,
  parameter int NBITS      = 31,
  parameter int NWORDS_MAX = 6,
  parameter int WORD_W     = 16,
  parameter int DLY_W      = 12,
  parameter int MAX_DEPTH  = trc_pkg::depth_of(MEM_UNITS, 0),
  parameter int AW         = $clog2(MAX_DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [1:0]                   mode_i,
  input  logic [7:0]                   period_i,
  input  logic [2:0]                   nwords_i,
  input  logic signed [DLY_W-1:0]      delay_i,
  input  logic                         tick_i,
  input  logic                         scan_i,
  input  logic                         req_i,
  input  logic                         trig_i,
  input  logic [NBITS-1:0]             bits_i,
  input  logic [NWORDS_MAX*WORD_W-1:0] words_i,
  input  logic [AW-1:0]                rd_idx_i,
  output logic [NBITS-1:0]             rd_bits_o,
  output logic [NWORDS_MAX*WORD_W-1:0] rd_words_o,
  output logic                         busy_o,
  output logic                         triggered_o,
  output logic                         done_o,
  output logic                         err_o
);
  localparam int WW = NWORDS_MAX * WORD_W;
  localparam int DW = NBITS + WW;
  localparam int CW = AW + 2;

  logic [1:0]    mode_q;
  logic [7:0]    per_q;
  logic [2:0]    nw_q;
  logic          stb, we;
  logic [AW-1:0] wa, ra;
  logic [WW-1:0] wd_words;
  logic [DW-1:0] rd_data;

  for (genvar j = 0; j < NWORDS_MAX; j++) begin : g_lane
    assign wd_words[j*WORD_W +: WORD_W] =
      (3'(j) < nw_q) ? words_i[j*WORD_W +: WORD_W] : '0;
  end

  trc_strobe i_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (busy_o),
    .mode_i (mode_q),
    .per_i  (per_q),
    .tick_i (tick_i),
    .scan_i (scan_i),
    .req_i  (req_i),
    .stb_o  (stb)
  );

  trc_ctrl #(
    .MEM_UNITS  (MEM_UNITS),
    .NWORDS_MAX (NWORDS_MAX),
    .AW         (AW),
    .CW         (CW),
    .DLY_W      (DLY_W)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .period_i (period_i),
    .nwords_i (nwords_i),
    .delay_i  (delay_i),
    .stb_i    (stb),
    .trig_i   (trig_i),
    .rd_idx_i (rd_idx_i),
    .mode_o   (mode_q),
    .per_o    (per_q),
    .nw_o     (nw_q),
    .we_o     (we),
    .wa_o     (wa),
    .ra_o     (ra),
    .busy_o   (busy_o),
    .trig_o   (triggered_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  trc_ram #(
    .DW    (DW),
    .DEPTH (MAX_DEPTH),
    .AW    (AW)
  ) i_ram (
    .clk_i (clk_i),
    .we_i  (we),
    .wa_i  (wa),
    .wd_i  ({wd_words, bits_i}),
    .ra_i  (ra),
    .rd_o  (rd_data)
  );

  assign rd_bits_o  = rd_data[NBITS-1:0];
  assign rd_words_o = rd_data[DW-1:NBITS];
endmodule

// File: rtl/trc_chk.sv
module trc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic triggered_o,
  input logic done_o,
  input logic err_o
);
  // R2
  start_arms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && !done_o && !triggered_o);

  // R6
  done_after_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> triggered_o && !busy_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && triggered_o);

  // R7
  err_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(err_o));

  // R4
  trig_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(triggered_o) |-> busy_o);
endmodule

bind trace_capture trc_chk i_trc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .triggered_o (triggered_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_trace_capture.sv
module test_trace_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd2;
  logic [7:0]  period_i = 8'd1;
  logic [2:0]  nwords_i = 3'd6;
  logic signed [11:0] delay_i = '0;
  logic        tick_i = 1'b0, scan_i = 1'b0, req_i = 1'b0, trig_i = 1'b0;
  logic [30:0] bits_i = '0;
  logic [95:0] words_i = '0;
  logic [8:0]  rd_idx_i = '0;
  logic [30:0] rd_bits_o;
  logic [95:0] rd_words_o;
  logic        busy_o, triggered_o, done_o, err_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  trace_capture i_trace_capture (
    .clk_i, .rst_ni, .start_i, .mode_i, .period_i, .nwords_i, .delay_i,
    .tick_i, .scan_i, .req_i, .trig_i, .bits_i, .words_i, .rd_idx_i,
    .rd_bits_o, .rd_words_o, .busy_o, .triggered_o, .done_o, .err_o
  );

  localparam int DEP [7] = '{400, 266, 200, 160, 132, 114, 100};
  localparam int NV = 8;
  localparam int V_NW    [NV] = '{6, 6, 6, 6, 6, 0, 2, 2};
  localparam int V_DLY   [NV] = '{0, -10, 5, -100, 300, 0, -99, -100};
  localparam int V_TRIG  [NV] = '{20, 30, 10, 60, 0, 0, 150, 150};
  localparam int V_FIRST [NV] = '{20, 20, 15, 11, 50, 0, 51, 51};
  localparam int V_ERR   [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int mode, input int per, input int nw, input int dly);
    @(negedge clk_i);
    mode_i = 2'(mode); period_i = 8'(per); nwords_i = 3'(nw); delay_i = 12'(dly);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // kind: 0 tick, 1 scan, 2 request
  task automatic pulse(input int kind, input int n, input logic trg);
    @(negedge clk_i);
    bits_i = 31'(n);
    for (int j = 0; j < 6; j++) words_i[j*16 +: 16] = 16'(n + 1000 * j);
    trig_i = trg;
    tick_i = (kind == 0); scan_i = (kind == 1); req_i = (kind == 2);
    @(negedge clk_i);
    tick_i = 1'b0; scan_i = 1'b0; req_i = 1'b0; trig_i = 1'b0;
  endtask

  task automatic rd(input int idx);
    @(negedge clk_i);
    rd_idx_i = 9'(idx);
    @(negedge clk_i);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int dep;
    int first;
    repeat (3) @(negedge clk_i);
    chk("R1 busy in reset", longint'(busy_o), 0);
    chk("R1 triggered in reset", longint'(triggered_o), 0);
    chk("R1 done in reset", longint'(done_o), 0);
    chk("R1 err in reset", longint'(err_o), 0);
    rst_ni = 1'b1;

    // table-driven request-mode scenarios
    for (int v = 0; v < NV; v++) begin
      do_start(2, 1, V_NW[v], V_DLY[v]);
      chk("R2 busy after start", longint'(busy_o), 1);
      chk("R2 done cleared", longint'(done_o), 0);
      chk("R7 err flag", longint'(err_o), V_ERR[v]);
      dep = DEP[V_NW[v]];
      first = V_FIRST[v];
      n = 0;
      while (!done_o && n < 1000) begin
        pulse(2, n, n >= V_TRIG[v]);
        if (n == V_TRIG[v]) chk("R4 triggered at trigger sample", longint'(triggered_o), 1);
        n++;
      end
      chk("R6 samples until done", n, first + dep);
      chk("R6 busy low at done", longint'(busy_o), 0);
      chk("R5 depth via window end", longint'(first + dep - 1), V_TRIG[v] +
          ((V_DLY[v] > dep / 2) ? dep / 2 : (V_DLY[v] < 1 - dep / 2) ? 1 - dep / 2 : V_DLY[v]) + dep - 1);
      rd(0);
      chk("R8 oldest sample", longint'(rd_bits_o), first);
      rd(dep - 1);
      chk("R5 newest sample", longint'(rd_bits_o), first + dep - 1);
      rd(dep / 2);
      for (int j = 0; j < 6; j++)
        chk("R8 word lane", longint'(rd_words_o[j*16 +: 16]),
            (j < V_NW[v]) ? longint'(16'(first + dep / 2 + 1000 * j)) : 0);
    end

    // R9: strobes after done are ignored
    pulse(2, 7777, 1'b1);
    pulse(2, 7778, 1'b1);
    chk("R9 done held", longint'(done_o), 1);
    rd(0);
    chk("R9 window unchanged", longint'(rd_bits_o), 51);

    // R3 periodic: period 3, trigger true from the start
    do_start(0, 3, 6, 0);
    for (int k = 1; k <= 300; k++) begin
      pulse(0, k, 1'b1);
      if (k == 299) chk("R3 not done before last timer sample", longint'(done_o), 0);
    end
    chk("R3 done after 100 timer samples", longint'(done_o), 1);
    rd(0);
    chk("R3 first timer sample", longint'(rd_bits_o), 3);
    rd(99);
    chk("R3 last timer sample", longint'(rd_bits_o), 300);

    // R3 scan mode, request pulses interleaved and ignored
    do_start(1, 1, 6, 0);
    n = 0;
    while (!done_o && n < 1000) begin
      pulse(1, n, n >= 5);
      pulse(2, 5000 + n, 1'b1);
      n++;
    end
    chk("R3 scan samples until done", n, 105);
    rd(0);
    chk("R3 scan oldest", longint'(rd_bits_o), 5);
    rd(1);
    chk("R3 request ignored in scan mode", longint'(rd_bits_o), 6);

    // R2 restart while busy
    do_start(2, 1, 6, 0);
    for (int k = 0; k < 10; k++) pulse(2, k, k >= 3);
    chk("R2 busy mid capture", longint'(busy_o), 1);
    do_start(2, 1, 6, 0);
    chk("R2 triggered cleared on restart", longint'(triggered_o), 0);
    n = 0;
    while (!done_o && n < 1000) begin
      pulse(2, 500 + n, 1'b1);
      n++;
    end
    chk("R2 restart sample count", n, 100);
    rd(0);
    chk("R2 restart oldest", longint'(rd_bits_o), 500);

    // R1 reset during capture
    do_start(2, 1, 6, 0);
    pulse(2, 1, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 busy cleared by reset", longint'(busy_o), 0);
    chk("R1 triggered cleared by reset", longint'(triggered_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    finish_run();
  end
endmodule